// File: doc/BRIEF.md
# I2C Bus Stall Watchdog

This block watches an I2C controller for transfers that stop making progress. A programmable down-counter is armed whenever the controller reports forward progress: a byte moved, an address or general-call match, a NACK, or a START on either side. It then counts down on a tick taken from the peripheral clock through a power-of-two prescaler. If it reaches zero before the next sign of progress, a sticky stall flag rises and stays high until a clear pulse removes it.

Events that end or abandon a transfer stop the countdown. These are a STOP on either side, the slave side not being addressed, lost arbitration and a bus error. A stopped counter waits for the next progress event. Software programs the preload value and the prescaler through a single 32-bit control word. A new setting applies from the next reload, so a countdown already running keeps the setting it started with.

Top module: `i2c_tmo_watch`

## Requirements
- R1: The control word resets to zero. A write places the prescaler select in bits [18:16] and the preload in bits [15:0]. It reads back on the next cycle with bits [31:19] as zero.
- R2: While running, the counter moves one step every 2^PSC clock cycles. With preload N, the flag rises on the clock edge exactly N*2^PSC cycles after the edge that sampled the reload event.
- R3: Each of the six progress inputs reloads the counter and starts a full countdown, whether the counter was halted or mid-count. The six inputs are receive-full, transmit-empty, receive-ready, NACK, general-call and address-match.
- R4: A master-issued START or a slave-detected START reloads and starts the countdown in the same way.
- R5: Each of the five halt inputs stops a running countdown, so no timeout follows. The halt inputs are master STOP, slave STOP, not-addressed, arbitration lost and bus error.
- R6: The stall flag stays set until a clear pulse. A clear removes it on the next edge. With no new reload, it stays clear afterwards, because the counter stops once it expires.
- R7: A preload of zero disables the watchdog: a reload does not start a countdown and the flag never rises.
- R8: A reload and a halt in the same cycle leave the counter loaded but halted. A later reload alone starts a full countdown.
- R9: A control write during a countdown does not change that countdown's length. The next reload uses the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| ev_rx_full | input | 1 | Progress: receive buffer full |
| ev_tx_empty | input | 1 | Progress: transmit data empty |
| ev_rx_ready | input | 1 | Progress: receive data not empty |
| ev_nack | input | 1 | Progress: NACK received |
| ev_gencall | input | 1 | Progress: general-call match |
| ev_addr_hit | input | 1 | Progress: own address match |
| ev_mst_start | input | 1 | START issued by the master side |
| ev_slv_start | input | 1 | START detected by the slave side |
| ev_mst_stop | input | 1 | STOP issued by the master side |
| ev_slv_stop | input | 1 | STOP detected by the slave side |
| ev_not_addr | input | 1 | Slave side not addressed |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error flagged |
| tmo_clr | input | 1 | Clear pulse for the stall flag |
| tmo_flag | output | 1 | Sticky stall (timeout) flag |

## Verification
The assertions assume that every event input and the clear input are single-cycle pulses, and that reset is held across at least one clock edge. They also assume the control word changes only on cycles with the write strobe. The stimulus drives each event, clear and write as a pulse that is set and dropped on falling edges, one cycle wide. It asserts a reload and a halt together only in the collision scenario. Timing checks sample the flag on the falling edges just before and just after the edge where the timeout is due.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int PSC_W   = 3;
    localparam int PSC_LSB = 16;
    localparam int DIV_W   = (1 << PSC_W) - 1;
    localparam int NPROG   = 6;
    localparam int NHALT   = 5;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] preload;
    } tmo_cfg_t;

    typedef struct packed {
        logic reload;
        logic halt;
    } tmo_ctl_t;

    function automatic tmo_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        tmo_cfg_t r;
        r.psc     = w[PSC_LSB +: PSC_W];
        r.preload = w[CNT_W-1:0];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input tmo_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PSC_LSB +: PSC_W] = c.psc;
        w[CNT_W-1:0]        = c.preload;
        return w;
    endfunction

    function automatic logic [DIV_W-1:0] div_mask(input logic [PSC_W-1:0] p);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i < int'(p));
        end
        return m;
    endfunction
endpackage

// File: rtl/i2c_tmo_cfg.sv
module i2c_tmo_cfg
    import i2c_tmo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output tmo_cfg_t          cfg,
    output logic [WORD_W-1:0] rdata
);
    tmo_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= word_to_cfg(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_to_word(cfg_q);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/i2c_tmo_evt.sv
module i2c_tmo_evt
    import i2c_tmo_pkg::*;
(
    input  logic [NPROG-1:0] prog_ev,
    input  logic [1:0]       start_ev,
    input  logic [NHALT-1:0] halt_ev,
    output tmo_ctl_t         ctl
);
    always_comb begin
        ctl.reload = (|prog_ev) | (|start_ev);
        ctl.halt   = |halt_ev;
    end
endmodule

// File: rtl/i2c_tmo_presc.sv
module i2c_tmo_presc
    import i2c_tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = div_mask(psc);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && ((div_q & mask) == mask);

    // R2
    div_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run && !restart |=> $stable(div_q));
endmodule

// File: rtl/i2c_tmo_down.sv
module i2c_tmo_down
    import i2c_tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tmo_ctl_t         ctl,
    input  tmo_cfg_t         cfg,
    input  logic             tick,
    input  logic             clr,
    output logic             run,
    output logic [PSC_W-1:0] act_psc,
    output logic             flag
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             expire;

    assign step   = run && tick && !ctl.reload && !ctl.halt;
    assign expire = step && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            run     <= 1'b0;
            act_psc <= '0;
        end else if (ctl.reload) begin
            cnt_q   <= cfg.preload;
            act_psc <= cfg.psc;
            run     <= !ctl.halt && (cfg.preload != '0);
        end else if (ctl.halt) begin
            run <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
            if (expire) run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flag && clr && !tick |=> !flag);
    // R5
    halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.halt |=> !run);
    // R7
    zero_preload_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.reload && (cfg.preload == '0) |=> !run);
    // R2
    cnt_still_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.reload && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_tmo_watch.sv
module i2c_tmo_watch
    import i2c_tmo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ev_rx_full,
    input  logic        ev_tx_empty,
    input  logic        ev_rx_ready,
    input  logic        ev_nack,
    input  logic        ev_gencall,
    input  logic        ev_addr_hit,
    input  logic        ev_mst_start,
    input  logic        ev_slv_start,
    input  logic        ev_mst_stop,
    input  logic        ev_slv_stop,
    input  logic        ev_not_addr,
    input  logic        ev_arb_lost,
    input  logic        ev_bus_err,
    input  logic        tmo_clr,
    output logic        tmo_flag
);
    tmo_cfg_t         cfg;
    tmo_ctl_t         ctl;
    logic             run;
    logic             tick;
    logic [PSC_W-1:0] act_psc;

    i2c_tmo_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    i2c_tmo_evt u_evt (
        .prog_ev  ({ev_addr_hit, ev_gencall, ev_nack, ev_rx_ready, ev_tx_empty, ev_rx_full}),
        .start_ev ({ev_slv_start, ev_mst_start}),
        .halt_ev  ({ev_bus_err, ev_arb_lost, ev_not_addr, ev_slv_stop, ev_mst_stop}),
        .ctl      (ctl)
    );

    i2c_tmo_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.reload),
        .run     (run),
        .psc     (act_psc),
        .tick    (tick)
    );

    i2c_tmo_down u_down (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .cfg     (cfg),
        .tick    (tick),
        .clr     (tmo_clr),
        .run     (run),
        .act_psc (act_psc),
        .flag    (tmo_flag)
    );
endmodule

// File: tb/i2c_tmo_watch_bench.sv
module i2c_tmo_watch_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  prog = '0;
    logic [1:0]  strt = '0;
    logic [4:0]  halt = '0;
    logic        tmo_clr = 1'b0;
    logic        tmo_flag;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tmo_watch u_i2c_tmo_watch (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .ev_rx_full   (prog[0]),
        .ev_tx_empty  (prog[1]),
        .ev_rx_ready  (prog[2]),
        .ev_nack      (prog[3]),
        .ev_gencall   (prog[4]),
        .ev_addr_hit  (prog[5]),
        .ev_mst_start (strt[0]),
        .ev_slv_start (strt[1]),
        .ev_mst_stop  (halt[0]),
        .ev_slv_stop  (halt[1]),
        .ev_not_addr  (halt[2]),
        .ev_arb_lost  (halt[3]),
        .ev_bus_err   (halt[4]),
        .tmo_clr      (tmo_clr),
        .tmo_flag     (tmo_flag)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] p, input logic [1:0] s, input logic [4:0] h);
        @(negedge clk); prog = p; strt = s; halt = h;
        @(negedge clk); prog = '0; strt = '0; halt = '0;
    endtask

    task automatic clear_flag();
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
    endtask

    // called right after pulse(): flag must rise exactly 'cycles' edges after the reload edge
    task automatic expect_timeout(input string req, input int cycles);
        wait_cyc(cycles - 1);
        check({req, " early"}, 32'(tmo_flag), 32'd0);
        wait_cyc(1);
        check({req, " due"}, 32'(tmo_flag), 32'd1);
    endtask

    task automatic t_reset();
        check("R1 reset word", cfg_rdata, 32'h0);
        check("R1 reset flag", 32'(tmo_flag), 32'd0);
    endtask

    task automatic t_regs();
        write_cfg(32'hFFFF_FFFF);
        check("R1 reserved bits read zero", cfg_rdata, 32'h0007_FFFF);
        write_cfg(32'h0005_1234);
        check("R1 field placement", cfg_rdata, 32'h0005_1234);
    endtask

    task automatic t_rates();
        write_cfg(32'h0000_0005);
        clear_flag();
        pulse(6'b000001, 2'b00, 5'b0);
        expect_timeout("R2 R3 psc0 n5", 5);
        wait_cyc(20);
        check("R6 flag sticky", 32'(tmo_flag), 32'd1);
        write_cfg(32'h0003_0004);
        clear_flag();
        pulse(6'b0, 2'b01, 5'b0);
        expect_timeout("R2 R4 psc3 n4", 32);
        write_cfg(32'h0007_0002);
        clear_flag();
        pulse(6'b0, 2'b10, 5'b0);
        expect_timeout("R2 R4 psc7 n2", 256);
    endtask

    task automatic t_sources();
        write_cfg(32'h0000_0006);
        for (int i = 0; i < 6; i++) begin
            clear_flag();
            pulse(6'(1 << i), 2'b00, 5'b0);
            expect_timeout($sformatf("R3 progress source %0d", i), 6);
        end
        for (int i = 0; i < 2; i++) begin
            clear_flag();
            pulse(6'b0, 2'(1 << i), 5'b0);
            expect_timeout($sformatf("R4 start source %0d", i), 6);
        end
        clear_flag();
        pulse(6'b000001, 2'b00, 5'b0);
        wait_cyc(3);
        pulse(6'b100000, 2'b00, 5'b0);
        expect_timeout("R3 mid-count reload", 6);
    endtask

    task automatic t_halts();
        write_cfg(32'h0000_0006);
        for (int j = 0; j < 5; j++) begin
            clear_flag();
            pulse(6'b000010, 2'b00, 5'b0);
            wait_cyc(2);
            pulse(6'b0, 2'b00, 5'(1 << j));
            wait_cyc(12);
            check($sformatf("R5 halt source %0d", j), 32'(tmo_flag), 32'd0);
        end
    endtask

    task automatic t_collide();
        write_cfg(32'h0000_0006);
        clear_flag();
        pulse(6'b000100, 2'b00, 5'b00001);
        wait_cyc(12);
        check("R8 reload with halt stays halted", 32'(tmo_flag), 32'd0);
        pulse(6'b0, 2'b10, 5'b0);
        expect_timeout("R8 restart after halt", 6);
    endtask

    task automatic t_zero();
        write_cfg(32'h0000_0000);
        clear_flag();
        pulse(6'b001000, 2'b00, 5'b0);
        wait_cyc(30);
        check("R7 zero preload disables", 32'(tmo_flag), 32'd0);
    endtask

    task automatic t_clear();
        write_cfg(32'h0001_0003);
        clear_flag();
        pulse(6'b010000, 2'b00, 5'b0);
        expect_timeout("R6 setup psc1 n3", 6);
        clear_flag();
        check("R6 clear removes flag", 32'(tmo_flag), 32'd0);
        wait_cyc(30);
        check("R6 no re-trigger without reload", 32'(tmo_flag), 32'd0);
    endtask

    task automatic t_late_write();
        write_cfg(32'h0000_000A);
        clear_flag();
        pulse(6'b000001, 2'b00, 5'b0);
        write_cfg(32'h0000_0003);
        wait_cyc(7);
        check("R9 old length kept early", 32'(tmo_flag), 32'd0);
        wait_cyc(1);
        check("R9 old length kept due", 32'(tmo_flag), 32'd1);
        clear_flag();
        pulse(6'b000001, 2'b00, 5'b0);
        expect_timeout("R9 new length at next reload", 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_rates();
        t_sources();
        t_halts();
        t_collide();
        t_zero();
        t_clear();
        t_late_write();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule